// File: doc/BRIEF.md
# Self-Routing Omega Multistage Switch

This block connects N source ports to N destination ports, N a power of two, through log2(N) columns of two-by-two switch cells. Each column holds N/2 cells, so the fabric holds (N/2)·log2(N) cells. Ahead of every column the lines are re-ordered by a perfect shuffle: a line index moves to the position given by rotating its bits one place to the left. Each cell steers a packet by looking at a single bit of that packet's destination. Column k reads destination bit log2(N)-1-k, so the bits are consumed from the most significant end. A 0 bit selects the cell's upper output and a 1 bit selects its lower output. No central controller is involved.

There is exactly one path through the fabric for each source and destination pair. Two packets therefore collide whenever they need the same cell output in the same column. The cell detects the collision on the spot. The packet on its upper input keeps the output. The packet on its lower input is discarded, and a blocked flag is raised for the source that sent it. Every packet travels with the index of its source, so each delivered payload can be traced back to its origin.

The fabric itself is combinational. A parameter adds one register stage on the outputs, and that register stage is on by default.

Top module: `omega_net`

## Requirements
- R1: A lone valid packet entering at any source with any destination d is presented on output line d, with out_valid set on that line only.
- R2: A delivered packet carries its payload and its source index unchanged: out_data[d] equals the payload of the source and out_src[d] equals the source number.
- R3: Two valid packets from sources s and t collide at column k exactly when their line numbers after column k are equal. The line number of a packet after column k is its source's low log2(N)-1-k bits followed by its destination's top k+1 bits. A collision is settled at the first column where these line numbers become equal.
- R4: In a collision the winner is the packet on the cell's upper input. That is the packet whose line number before the column, or whose source index at column 0, has a most significant bit of 0.
- R5: A losing packet is removed from the outputs and blocked[s] is set for its source s. Every valid source ends up either delivered on exactly one output or flagged as blocked, never both.
- R6: An output line that receives no packet has out_valid at 0.
- R7: Inputs whose in_valid bit is 0 have no effect, whatever their destination and payload: they produce no output and no blocked flag.
- R8: With the output register enabled (the default), outputs and flags show the result for the inputs present at the previous rising clock edge. A low rst_n clears every out_valid and blocked bit.
- R9: Any uniform shift, where every source s sends to (s+c) mod N, passes with no blocked source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register stage |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | N | Per-source packet present |
| in_dest | input | N×log2(N) | Per-source destination address |
| in_data | input | N×W | Per-source payload |
| out_valid | output | N | Per-destination packet present |
| out_src | output | N×log2(N) | Source index of the delivered packet |
| out_data | output | N×W | Payload of the delivered packet |
| blocked | output | N | Per-source flag: packet lost in a collision |

## Verification
A cell that misreads its select bit, or a shuffle link wired to the wrong line, sends a packet to an output that differs from its destination. The error shows in out_valid and out_src in the very cycle that result is registered. A wrong collision decision shows in that same cycle in two ways. The wrong source appears in blocked. The number of delivered packets plus the number of blocked flags also stops matching the number of valid sources. The sweeps cover every single-packet route and every pair of sources with every pair of destinations, so each column's collision rule is exercised at every cell.

// File: rtl/omega_pkg.sv
// Shared helpers for the Omega switch fabric.
// Assumes line indices fit in lg bits with lg >= 1.
package omega_pkg;

    // Position a line moves to under a perfect shuffle: rotate left by one bit.
    function automatic int shuffle_pos(input int idx, input int lg);
        return ((idx << 1) | (idx >> (lg - 1))) & ((1 << lg) - 1);
    endfunction

endpackage

// File: rtl/omega_switch.sv
// Two-by-two routing cell. It steers each packet to the upper output (bit 0)
// or the lower output (bit 1) according to bit SEL of the packet's destination.
// On a collision the upper input wins; the lower packet is reported as dropped.
// Assumes SEL < LG.
module omega_switch #(
    parameter int LG  = 3,
    parameter int W   = 8,
    parameter int SEL = 0
) (
    input  logic          up_v,
    input  logic [LG-1:0] up_dst,
    input  logic [LG-1:0] up_src,
    input  logic [W-1:0]  up_dat,
    input  logic          lo_v,
    input  logic [LG-1:0] lo_dst,
    input  logic [LG-1:0] lo_src,
    input  logic [W-1:0]  lo_dat,
    output logic          o0_v,
    output logic [LG-1:0] o0_dst,
    output logic [LG-1:0] o0_src,
    output logic [W-1:0]  o0_dat,
    output logic          o1_v,
    output logic [LG-1:0] o1_dst,
    output logic [LG-1:0] o1_src,
    output logic [W-1:0]  o1_dat,
    output logic          drop,
    output logic [LG-1:0] drop_src
);

    // Upper output: the upper input has priority over the lower input.
    always_comb begin
        o0_v = 1'b0; o0_dst = '0; o0_src = '0; o0_dat = '0;
        if (up_v && !up_dst[SEL]) begin
            o0_v = 1'b1; o0_dst = up_dst; o0_src = up_src; o0_dat = up_dat;
        end else if (lo_v && !lo_dst[SEL]) begin
            o0_v = 1'b1; o0_dst = lo_dst; o0_src = lo_src; o0_dat = lo_dat;
        end
    end

    // Lower output: the upper input has priority over the lower input.
    always_comb begin
        o1_v = 1'b0; o1_dst = '0; o1_src = '0; o1_dat = '0;
        if (up_v && up_dst[SEL]) begin
            o1_v = 1'b1; o1_dst = up_dst; o1_src = up_src; o1_dat = up_dat;
        end else if (lo_v && lo_dst[SEL]) begin
            o1_v = 1'b1; o1_dst = lo_dst; o1_src = lo_src; o1_dat = lo_dat;
        end
    end

    // Collision: both inputs valid and asking for the same side.
    assign drop     = up_v && lo_v && (up_dst[SEL] == lo_dst[SEL]);
    assign drop_src = lo_src;

endmodule

// File: rtl/omega_stage.sv
// One column of the fabric: a perfect shuffle of the N lines followed by N/2
// routing cells that select on destination bit LG-1-STAGE.
// Assumes N is a power of two and N >= 2.
module omega_stage #(
    parameter int N     = 8,
    parameter int W     = 8,
    parameter int STAGE = 0,
    localparam int LG   = $clog2(N),
    localparam int HALF = N / 2
) (
    input  logic [N-1:0]            in_v,
    input  logic [N-1:0][LG-1:0]    in_dst,
    input  logic [N-1:0][LG-1:0]    in_src,
    input  logic [N-1:0][W-1:0]     in_dat,
    output logic [N-1:0]            out_v,
    output logic [N-1:0][LG-1:0]    out_dst,
    output logic [N-1:0][LG-1:0]    out_src,
    output logic [N-1:0][W-1:0]     out_dat,
    output logic [HALF-1:0]         drop_v,
    output logic [HALF-1:0][LG-1:0] drop_src
);

    logic [N-1:0]         sh_v;
    logic [N-1:0][LG-1:0] sh_dst;
    logic [N-1:0][LG-1:0] sh_src;
    logic [N-1:0][W-1:0]  sh_dat;

    // Shuffle links: line i lands on its left-rotated position.
    for (genvar i = 0; i < N; i++) begin : g_shuf
        localparam int P = omega_pkg::shuffle_pos(i, LG);
        assign sh_v[P]   = in_v[i];
        assign sh_dst[P] = in_dst[i];
        assign sh_src[P] = in_src[i];
        assign sh_dat[P] = in_dat[i];
    end

    // Routing cells: cell m serves lines 2m (upper) and 2m+1 (lower).
    for (genvar m = 0; m < HALF; m++) begin : g_cell
        omega_switch #(.LG(LG), .W(W), .SEL(LG - 1 - STAGE)) u_sw (
            .up_v    (sh_v[2*m]),     .up_dst (sh_dst[2*m]),
            .up_src  (sh_src[2*m]),   .up_dat (sh_dat[2*m]),
            .lo_v    (sh_v[2*m+1]),   .lo_dst (sh_dst[2*m+1]),
            .lo_src  (sh_src[2*m+1]), .lo_dat (sh_dat[2*m+1]),
            .o0_v    (out_v[2*m]),    .o0_dst (out_dst[2*m]),
            .o0_src  (out_src[2*m]),  .o0_dat (out_dat[2*m]),
            .o1_v    (out_v[2*m+1]),  .o1_dst (out_dst[2*m+1]),
            .o1_src  (out_src[2*m+1]),.o1_dat (out_dat[2*m+1]),
            .drop    (drop_v[m]),     .drop_src(drop_src[m])
        );
    end

endmodule

// File: rtl/omega_net.sv
// N-port self-routing Omega fabric built from log2(N) shuffle-plus-cell columns.
// Every packet is tagged with its source index. Packets lost in a collision raise
// blocked[source]. The fabric is combinational, with an optional output register
// (REG_OUT). Assumes N is a power of two, N >= 2, and synchronous active-low reset.
module omega_net #(
    parameter int N       = 8,
    parameter int W       = 8,
    parameter bit REG_OUT = 1'b1,
    localparam int LG     = $clog2(N),
    localparam int HALF   = N / 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         in_valid,
    input  logic [N-1:0][LG-1:0] in_dest,
    input  logic [N-1:0][W-1:0]  in_data,
    output logic [N-1:0]         out_valid,
    output logic [N-1:0][LG-1:0] out_src,
    output logic [N-1:0][W-1:0]  out_data,
    output logic [N-1:0]         blocked
);

    logic [LG:0][N-1:0]            lv;
    logic [LG:0][N-1:0][LG-1:0]    ld;
    logic [LG:0][N-1:0][LG-1:0]    ls;
    logic [LG:0][N-1:0][W-1:0]     lp;
    logic [LG-1:0][HALF-1:0]         dv;
    logic [LG-1:0][HALF-1:0][LG-1:0] ds;
    logic [N-1:0]                  blk_c;
    logic                          unused_tail;

    // Column 0 input: tag each packet with its source index.
    assign lv[0] = in_valid;
    assign ld[0] = in_dest;
    assign lp[0] = in_data;
    for (genvar i = 0; i < N; i++) begin : g_tag
        assign ls[0][i] = LG'(i);
    end

    // Chain of columns.
    for (genvar k = 0; k < LG; k++) begin : g_col
        omega_stage #(.N(N), .W(W), .STAGE(k)) u_stage (
            .in_v    (lv[k]),   .in_dst  (ld[k]),
            .in_src  (ls[k]),   .in_dat  (lp[k]),
            .out_v   (lv[k+1]), .out_dst (ld[k+1]),
            .out_src (ls[k+1]), .out_dat (lp[k+1]),
            .drop_v  (dv[k]),   .drop_src(ds[k])
        );
    end

    // The final line index equals the destination, so the carried address is spent.
    assign unused_tail = ^ld[LG];

    // Gather drop reports from every cell into per-source flags.
    always_comb begin
        blk_c = '0;
        for (int i = 0; i < N; i++)
            for (int k = 0; k < LG; k++)
                for (int m = 0; m < HALF; m++)
                    if (dv[k][m] && ds[k][m] == LG'(i)) blk_c[i] = 1'b1;
    end

    if (REG_OUT) begin : g_reg
        // Output register: capture the fabric result each cycle.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                out_valid <= '0;
                out_src   <= '0;
                out_data  <= '0;
                blocked   <= '0;
            end else begin
                out_valid <= lv[LG];
                out_src   <= ls[LG];
                out_data  <= lp[LG];
                blocked   <= blk_c;
            end
        end
    end else begin : g_comb
        assign out_valid = lv[LG];
        assign out_src   = ls[LG];
        assign out_data  = lp[LG];
        assign blocked   = blk_c;
    end

endmodule

// File: rtl/omega_net_chk.sv
// Port-level checker for omega_net. It keeps its own one-cycle copy of the
// inputs so that outputs can be related to the packets that produced them.
module omega_net_chk #(
    parameter int N       = 8,
    parameter int W       = 8,
    parameter bit REG_OUT = 1'b1,
    localparam int LG     = $clog2(N)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [N-1:0]         in_valid,
    input logic [N-1:0][LG-1:0] in_dest,
    input logic [N-1:0][W-1:0]  in_data,
    input logic [N-1:0]         out_valid,
    input logic [N-1:0][LG-1:0] out_src,
    input logic [N-1:0][W-1:0]  out_data,
    input logic [N-1:0]         blocked
);

    logic [N-1:0]         iv_q;
    logic [N-1:0][LG-1:0] id_q;
    logic [N-1:0][W-1:0]  ip_q;
    logic [N-1:0]         ref_v;
    logic [N-1:0][LG-1:0] ref_d;
    logic [N-1:0][W-1:0]  ref_p;

    // Snapshot of the inputs, matching the latency of the output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iv_q <= '0; id_q <= '0; ip_q <= '0;
        end else begin
            iv_q <= in_valid; id_q <= in_dest; ip_q <= in_data;
        end
    end

    assign ref_v = REG_OUT ? iv_q : in_valid;
    assign ref_d = REG_OUT ? id_q : in_dest;
    assign ref_p = REG_OUT ? ip_q : in_data;

    for (genvar j = 0; j < N; j++) begin : g_out
        // R1: a delivered packet sits on the line equal to its destination.
        assert_route_R1: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[j] |-> (ref_v[out_src[j]] && ref_d[out_src[j]] == LG'(j)));
        // R2: the payload matches the tagged source.
        assert_payload_R2: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[j] |-> (out_data[j] == ref_p[out_src[j]]));
        // R5: only a valid source can be flagged blocked.
        assert_flag_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
            blocked[j] |-> ref_v[j]);
    end

    // R5: every valid source is delivered or blocked.
    assert_conserve_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(out_valid) + $countones(blocked)) == $countones(ref_v));

    // R7: with no valid source there is no output and no flag.
    assert_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_v == '0) |-> (out_valid == '0 && blocked == '0));

    // R8: right after reset the registered outputs are clear.
    assert_reset_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (REG_OUT && $rose(rst_n)) |-> (out_valid == '0 && blocked == '0));

endmodule

bind omega_net omega_net_chk #(.N(N), .W(W), .REG_OUT(REG_OUT)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dest(in_dest),
    .in_data(in_data), .out_valid(out_valid), .out_src(out_src),
    .out_data(out_data), .blocked(blocked)
);

// File: tb/tb_omega_net.sv
// Sweeps of the 8-port fabric with the output register enabled. Expected results
// come from the arithmetic line-number rule of the requirements.
module tb_omega_net;
    localparam int N  = 8;
    localparam int W  = 8;
    localparam int LG = 3;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [N-1:0]         sv = '0;
    logic [N-1:0][LG-1:0] sd = '0;
    logic [N-1:0][W-1:0]  sdat = '0;
    logic [N-1:0]         out_valid;
    logic [N-1:0][LG-1:0] out_src;
    logic [N-1:0][W-1:0]  out_data;
    logic [N-1:0]         blocked;

    logic [N-1:0]         exp_v, exp_b;
    logic [N-1:0][LG-1:0] exp_src;
    logic [N-1:0][W-1:0]  exp_dat;
    int errors = 0;
    int checks = 0;
    logic [31:0] rng = 32'h1234_5678;

    omega_net #(.N(N), .W(W), .REG_OUT(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(sv), .in_dest(sd), .in_data(sdat),
        .out_valid(out_valid), .out_src(out_src), .out_data(out_data),
        .blocked(blocked)
    );

    always #10 clk = ~clk;

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    function automatic logic [31:0] next_rng(input logic [31:0] x);
        logic [31:0] y = x;
        y ^= y << 13; y ^= y >> 17; y ^= y << 5;
        return y;
    endfunction

    // Expected outcome from the line-number rule (R3) and the upper-wins rule (R4).
    task automatic model();
        logic [N-1:0] alive;
        int line[N];
        int nl[N];
        exp_v = '0; exp_b = '0; exp_src = '0; exp_dat = '0;
        alive = sv;
        for (int i = 0; i < N; i++) line[i] = i;
        for (int k = 0; k < LG; k++) begin
            for (int i = 0; i < N; i++)
                nl[i] = ((line[i] << 1) & (N - 1)) | int'(sd[i][LG-1-k]);
            for (int i = 0; i < N; i++)
                for (int j = i + 1; j < N; j++)
                    if (alive[i] && alive[j] && nl[i] == nl[j]) begin
                        int loser;
                        loser = (((line[i] >> (LG - 1)) & 1) == 0) ? j : i;
                        alive[loser] = 1'b0;
                        exp_b[loser] = 1'b1;
                    end
            for (int i = 0; i < N; i++) line[i] = nl[i];
        end
        for (int i = 0; i < N; i++)
            if (alive[i]) begin
                exp_v[line[i]]   = 1'b1;
                exp_src[line[i]] = LG'(i);
                exp_dat[line[i]] = sdat[i];
            end
    endtask

    // Compare the ports against the stored expectation; one check per call.
    task automatic compare(input string tag);
        logic bad = 1'b0;
        checks++;
        if (out_valid !== exp_v || blocked !== exp_b) bad = 1'b1;
        for (int j = 0; j < N; j++)
            if (exp_v[j] && (out_src[j] !== exp_src[j] || out_data[j] !== exp_dat[j]))
                bad = 1'b1;
        if (bad) begin
            errors++;
            $display("FAIL %s: valid=%b blocked=%b src=%h data=%h expected valid=%b blocked=%b src=%h data=%h",
                     tag, out_valid, blocked, out_src, out_data & mask_data(exp_v),
                     exp_v, exp_b, exp_src, exp_dat);
        end
    endtask

    function automatic logic [N-1:0][W-1:0] mask_data(input logic [N-1:0] m);
        logic [N-1:0][W-1:0] r = '0;
        for (int j = 0; j < N; j++) if (m[j]) r[j] = '1;
        return r;
    endfunction

    // Inputs are set at a falling edge; the result is registered at the next rising edge.
    task automatic run_vec(input string tag);
        model();
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic fill_garbage();
        for (int i = 0; i < N; i++) begin
            rng = next_rng(rng);
            sd[i]   = rng[LG-1:0];
            sdat[i] = rng[15:8];
        end
    endtask

    initial begin
        // R8: outputs clear while reset is held.
        sv = '1; fill_garbage();
        repeat (3) @(negedge clk);
        exp_v = '0; exp_b = '0; exp_src = '0; exp_dat = '0;
        compare("R8 reset state");
        rst_n = 1'b1;
        sv = '0;

        // R7: garbage on invalid inputs produces nothing.
        for (int t = 0; t < 8; t++) begin
            fill_garbage();
            run_vec("R7 invalid inputs ignored");
        end

        // R1, R2, R6: every single-packet route, other sources invalid with garbage.
        for (int s = 0; s < N; s++)
            for (int d = 0; d < N; d++) begin
                fill_garbage();
                sv = '0; sv[s] = 1'b1;
                sd[s] = LG'(d);
                sdat[s] = W'(s * 29 + d * 3 + 1);
                run_vec("R1 R2 R6 single route");
            end

        // R3, R4, R5: every source pair with every destination pair.
        for (int s = 0; s < N; s++)
            for (int t = s + 1; t < N; t++)
                for (int d = 0; d < N; d++)
                    for (int e = 0; e < N; e++) begin
                        fill_garbage();
                        sv = '0; sv[s] = 1'b1; sv[t] = 1'b1;
                        sd[s] = LG'(d); sd[t] = LG'(e);
                        run_vec("R3 R4 R5 pair collision");
                    end

        // R9: uniform shifts all pass without blocking.
        for (int c = 0; c < N; c++) begin
            fill_garbage();
            sv = '1;
            for (int i = 0; i < N; i++) sd[i] = LG'((i + c) % N);
            run_vec("R9 uniform shift");
            checks++;
            if (blocked !== '0 || out_valid !== '1) begin
                errors++;
                $display("FAIL R9 shift %0d: valid=%b blocked=%b expected valid=%b blocked=%b",
                         c, out_valid, blocked, {N{1'b1}}, {N{1'b0}});
            end
        end

        // R2, R5: random loads with random valid masks.
        for (int t = 0; t < 1500; t++) begin
            fill_garbage();
            rng = next_rng(rng);
            sv = (t % 3 == 0) ? '1 : rng[N-1:0];
            run_vec("R2 R5 random load");
        end

        // R8: inputs changing mid-cycle do not disturb registered outputs.
        sv = '1; fill_garbage();
        run_vec("R8 latency setup");
        sv = 8'h5A; fill_garbage();
        #3;
        compare("R8 output held until edge");
        run_vec("R8 next result");

        // R8: synchronous reset in mid-run clears outputs.
        sv = '1; fill_garbage();
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        exp_v = '0; exp_b = '0;
        compare("R8 reset mid-run");
        rst_n = 1'b1;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule